// File: doc/BRIEF.md
# Hold-and-Load Boot Controller

This block keeps a soft processor halted from reset and lets a host on a serial link put a program into the shared code/data memory, choose where execution begins, and then release the processor. It sits between an existing UART deserializer and serializer. Received bytes arrive already decoded. Replies go out through a valid/ready byte port. A select output decides whether the transmit line carries the processor's output or the controller's replies. The controller needs no boot ROM: all code comes from the host.

The host talks in fixed 11-byte command frames. Each frame has a sync byte, a command code, a big-endian word address, a big-endian data word and a closing checksum. The controller executes each frame that passes its checks and answers it. A frame that fails is dropped silently. A frame that stalls partway is dropped after a programmable number of idle clocks. The start command ends the load session. Once its acknowledge has fully left the serializer, the controller gives one start pulse, frees the processor and hands the transmit line back.

Top module: `hl_boot_ctl`

## Requirements
- R1: In the cycle after reset is released, `cpu_hold` is 1 and `tx_sel`, `cpu_start`, `mem_we`, `mem_re` and `tx_valid` are 0.
- R2: A frame is 11 received bytes in this order: 0x5A, command, address bits 31..0 most-significant byte first, data bits 31..0 most-significant byte first, and a checksum chosen so that all 11 bytes sum to 0 modulo 256. Bytes other than 0x5A received while no frame is open are ignored.
- R3: A frame with a wrong checksum, or with a command other than 0x01..0x04, is discarded. It produces no reply byte, no memory access and no change of `tx_sel`.
- R4: Every accepted frame sets `tx_sel` to 1 (controller owns transmit) and is answered with the byte 0xA5.
- R5: Command 0x01 (write word) while `cpu_hold` is 1 produces exactly one cycle of `mem_we` with `mem_addr` equal to the low MEM_AW bits of the address and `mem_wdata` equal to the data word.
- R6: Command 0x02 (read word) reads the memory word at the low MEM_AW address bits. Its reply is 0xA5 followed by the 4 data bytes, most-significant byte first. The memory returns `mem_rdata` one clock after `mem_re`.
- R7: Command 0x03 (set start address) while `cpu_hold` is 1 loads the data word into `cpu_start_addr`.
- R8: Command 0x04 (start) while `cpu_hold` is 1 raises `cpu_start` for exactly one clock. This happens only after the acknowledge byte has been accepted and `tx_ready` has returned high after at least one low cycle. On the same edge, `cpu_hold` and `tx_sel` go to 0.
- R9: While `cpu_hold` is 0, commands 0x01, 0x03 and 0x04 are acknowledged but cause no memory write, no change of `cpu_start_addr` and no start pulse.
- R10: If IDLE_LIMIT consecutive clocks pass with no received byte while a frame is open, the partial frame is dropped and the next byte is treated as a search for 0x5A. A gap shorter than that continues the frame.
- R11: Once `tx_valid` is high, it stays high with `tx_byte` unchanged until the cycle in which `tx_ready` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Serializer can take a byte (low while one is shifting out) |
| tx_valid | output | 1 | Reply byte offered to the serializer |
| tx_byte | output | 8 | Reply byte |
| tx_sel | output | 1 | Transmit mux select: 1 = controller, 0 = processor |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one clock after `mem_re` |
| cpu_hold | output | 1 | Keeps the processor halted |
| cpu_start | output | 1 | One-clock start pulse |
| cpu_start_addr | output | 32 | Address where the processor begins |

## Verification
Three effects of the start command land on the same clock edge: the start pulse, the release of `cpu_hold`, and the return of `tx_sel` to the processor side. That edge also has to come after the serializer has finished the acknowledge. The bench provokes this with a serializer model that keeps `tx_ready` low for a fixed number of clocks after each accepted byte. It records the cycle in which the acknowledge was taken and the cycle of the pulse, and requires the gap to exceed the busy time. The bench also checks the pulse width, the hold and select levels after the pulse, and that later start frames add no second pulse.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h5A;
  localparam logic [7:0] ACK_BYTE  = 8'hA5;

  localparam logic [7:0] CMD_WR    = 8'h01;
  localparam logic [7:0] CMD_RD    = 8'h02;
  localparam logic [7:0] CMD_SETPC = 8'h03;
  localparam logic [7:0] CMD_GO    = 8'h04;

  localparam int FRAME_BYTES = 11;
  localparam int REPLY_BYTES = 5;

  typedef enum logic [1:0] {
    EX_IDLE,
    EX_RD1,
    EX_RD2,
    EX_REPLY
  } exec_state_t;

  typedef enum logic [1:0] {
    RT_IDLE,
    RT_SEND,
    RT_FLUSH
  } reply_state_t;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_WR) || (c == CMD_RD) || (c == CMD_SETPC) || (c == CMD_GO);
  endfunction
endpackage

// File: rtl/hl_frame_rx.sv
module hl_frame_rx
  import hl_pkg::*;
#(
  parameter int MEM_AW     = 12,
  parameter int IDLE_LIMIT = 65535
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              frame_ok,
  output logic [7:0]        f_cmd,
  output logic [MEM_AW-1:0] f_addr,
  output logic [31:0]       f_data
);
  localparam int IW       = $clog2(IDLE_LIMIT + 1);
  localparam int IDX_W    = $clog2(FRAME_BYTES);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_LIMIT - 1);
  localparam logic [IDX_W-1:0] IDX_CMD  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DAT0 = IDX_W'(6);
  localparam logic [IDX_W-1:0] IDX_CHK  = IDX_W'(FRAME_BYTES - 1);

  logic [IDX_W-1:0]  idx;
  logic [7:0]        sum;
  logic [7:0]        cmd_r;
  logic [MEM_AW-1:0] addr_r;
  logic [31:0]       data_r;
  logic [IW-1:0]     idle_cnt;
  logic [7:0]        total;

  always_comb total = sum + rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      sum      <= '0;
      cmd_r    <= '0;
      addr_r   <= '0;
      data_r   <= '0;
      idle_cnt <= '0;
      frame_ok <= 1'b0;
      f_cmd    <= '0;
      f_addr   <= '0;
      f_data   <= '0;
    end else begin
      frame_ok <= 1'b0;
      if (rx_valid) begin
        idle_cnt <= '0;
        if (idx == '0) begin
          if (rx_byte == SYNC_BYTE) begin
            idx <= IDX_CMD;
            sum <= rx_byte;
          end
        end else if (idx == IDX_CHK) begin
          idx <= '0;
          if (total == 8'h00 && cmd_known(cmd_r)) begin
            frame_ok <= 1'b1;
            f_cmd    <= cmd_r;
            f_addr   <= addr_r;
            f_data   <= data_r;
          end
        end else begin
          sum <= total;
          idx <= idx + 1'b1;
          if (idx == IDX_CMD)
            cmd_r <= rx_byte;
          else if (idx < IDX_DAT0)
            addr_r <= MEM_AW'({addr_r, rx_byte});
          else
            data_r <= {data_r[23:0], rx_byte};
        end
      end else if (idx != '0) begin
        if (idle_cnt == IDLE_MAX) begin
          idx      <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hl_reply_tx.sv
module hl_reply_tx
  import hl_pkg::*;
#(
  parameter int NBYTES = REPLY_BYTES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [$clog2(NBYTES+1)-1:0]  load_len,
  input  logic [8*NBYTES-1:0]          load_data,
  input  logic                         tx_ready,
  output logic                         tx_valid,
  output logic [7:0]                   tx_byte,
  output logic                         done
);
  localparam int LW = $clog2(NBYTES + 1);
  localparam int DW = 8 * NBYTES;

  reply_state_t   st;
  logic [DW-1:0]  shreg;
  logic [LW-1:0]  left;
  logic           guard;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RT_IDLE;
      shreg    <= '0;
      left     <= '0;
      guard    <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RT_IDLE: begin
          if (load) begin
            tx_byte  <= load_data[DW-1 -: 8];
            shreg    <= load_data << 8;
            left     <= load_len - 1'b1;
            tx_valid <= 1'b1;
            st       <= RT_SEND;
          end
        end
        RT_SEND: begin
          if (tx_valid && tx_ready) begin
            if (left == '0) begin
              tx_valid <= 1'b0;
              guard    <= 1'b1;
              st       <= RT_FLUSH;
            end else begin
              tx_byte <= shreg[DW-1 -: 8];
              shreg   <= shreg << 8;
              left    <= left - 1'b1;
            end
          end
        end
        RT_FLUSH: begin
          if (guard) begin
            guard <= 1'b0;
          end else if (tx_ready) begin
            done <= 1'b1;
            st   <= RT_IDLE;
          end
        end
        default: st <= RT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hl_boot_ctl.sv
module hl_boot_ctl
  import hl_pkg::*;
#(
  parameter int MEM_AW     = 12,
  parameter int IDLE_LIMIT = 65535
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_sel,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              cpu_hold,
  output logic              cpu_start,
  output logic [31:0]       cpu_start_addr
);
  localparam int LW = $clog2(REPLY_BYTES + 1);
  localparam logic [LW-1:0] LEN_ACK  = LW'(1);
  localparam logic [LW-1:0] LEN_READ = LW'(REPLY_BYTES);

  logic              frame_ok;
  logic [7:0]        f_cmd;
  logic [MEM_AW-1:0] f_addr;
  logic [31:0]       f_data;

  logic                     rp_load;
  logic [LW-1:0]            rp_len;
  logic [8*REPLY_BYTES-1:0] rp_data;
  logic                     rp_done;

  exec_state_t st;
  logic        pend_start;

  hl_frame_rx #(.MEM_AW(MEM_AW), .IDLE_LIMIT(IDLE_LIMIT)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .frame_ok (frame_ok),
    .f_cmd    (f_cmd),
    .f_addr   (f_addr),
    .f_data   (f_data)
  );

  hl_reply_tx #(.NBYTES(REPLY_BYTES)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (rp_load),
    .load_len  (rp_len),
    .load_data (rp_data),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .done      (rp_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= EX_IDLE;
      tx_sel         <= 1'b0;
      mem_we         <= 1'b0;
      mem_re         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      cpu_hold       <= 1'b1;
      cpu_start      <= 1'b0;
      cpu_start_addr <= '0;
      pend_start     <= 1'b0;
      rp_load        <= 1'b0;
      rp_len         <= '0;
      rp_data        <= '0;
    end else begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      cpu_start <= 1'b0;
      rp_load   <= 1'b0;
      case (st)
        EX_IDLE: begin
          if (frame_ok) begin
            tx_sel    <= 1'b1;
            mem_addr  <= f_addr;
            mem_wdata <= f_data;
            rp_len    <= LEN_ACK;
            rp_data   <= {ACK_BYTE, 32'h0};
            if (f_cmd == CMD_RD) begin
              mem_re <= 1'b1;
              st     <= EX_RD1;
            end else begin
              rp_load <= 1'b1;
              st      <= EX_REPLY;
              if (f_cmd == CMD_WR)
                mem_we <= cpu_hold;
              if (f_cmd == CMD_SETPC && cpu_hold)
                cpu_start_addr <= f_data;
              if (f_cmd == CMD_GO)
                pend_start <= cpu_hold;
            end
          end
        end
        EX_RD1: st <= EX_RD2;
        EX_RD2: begin
          rp_len  <= LEN_READ;
          rp_data <= {ACK_BYTE, mem_rdata};
          rp_load <= 1'b1;
          st      <= EX_REPLY;
        end
        EX_REPLY: begin
          if (rp_done) begin
            st <= EX_IDLE;
            if (pend_start) begin
              pend_start <= 1'b0;
              cpu_start  <= 1'b1;
              cpu_hold   <= 1'b0;
              tx_sel     <= 1'b0;
            end
          end
        end
        default: st <= EX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hl_boot_chk.sv
module hl_boot_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       tx_sel,
  input logic       mem_we,
  input logic       mem_re,
  input logic       cpu_hold,
  input logic       cpu_start
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (cpu_hold && !tx_sel && !cpu_start && !mem_we && !mem_re && !tx_valid));

  assert_reply_owns_line_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_sel);

  assert_write_only_held_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> cpu_hold);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_start |=> !cpu_start);

  assert_start_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_start |-> (tx_ready && !tx_valid));

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_start |-> (!cpu_hold && !tx_sel));

  assert_line_return_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_sel) |-> cpu_start);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_hold) |-> cpu_start);

  assert_tx_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

bind hl_boot_ctl hl_boot_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_ready  (tx_ready),
  .tx_valid  (tx_valid),
  .tx_byte   (tx_byte),
  .tx_sel    (tx_sel),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .cpu_hold  (cpu_hold),
  .cpu_start (cpu_start)
);

// File: tb/sim_hl_boot_ctl.sv
module sim_hl_boot_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int LIMIT      = 400;
  localparam int BYTE_CYC   = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = 8'h00;
  logic          tx_ready;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          tx_sel;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = 32'h0;
  logic          cpu_hold, cpu_start;
  logic [31:0]   cpu_start_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_boot_ctl #(.MEM_AW(AW), .IDLE_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_sel(tx_sel),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cpu_hold(cpu_hold), .cpu_start(cpu_start),
    .cpu_start_addr(cpu_start_addr)
  );

  int nchk = 0;
  int nerr = 0;

  // serializer, memory and pulse monitors
  int          cyc = 0;
  int          busy = 0;
  logic [7:0]  txlog [0:255];
  int          nlog = 0;
  int          last_acc = 0;
  logic [31:0] mem [0:(1<<AW)-1];
  int          nwr = 0;
  logic [AW-1:0] last_wa = '0;
  logic [31:0] last_wd = '0;
  int          nstart = 0;
  int          start_cyc = 0;
  int          wide_err = 0;
  int          hs_err = 0;
  logic        prev_start = 1'b0;
  logic        prev_valid = 1'b0;
  logic        prev_ready = 1'b0;
  logic [7:0]  prev_byte = 8'h00;

  assign tx_ready = (busy == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      busy <= 0;
    end else if (tx_valid && tx_ready) begin
      txlog[nlog[7:0]] = tx_byte;
      nlog = nlog + 1;
      last_acc = cyc;
      busy <= BYTE_CYC;
    end else if (busy != 0) begin
      busy <= busy - 1;
    end
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      nwr = nwr + 1;
      last_wa = mem_addr;
      last_wd = mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (cpu_start) begin
      nstart = nstart + 1;
      start_cyc = cyc;
      if (prev_start) wide_err = wide_err + 1;
    end
    if (!rst && prev_valid && !prev_ready && (!tx_valid || tx_byte != prev_byte))
      hs_err = hs_err + 1;
    prev_start = cpu_start;
    prev_valid = tx_valid;
    prev_ready = tx_ready;
    prev_byte  = tx_byte;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] fb [0:10];

  task automatic build(input logic [7:0] cmd, input logic [31:0] addr,
                       input logic [31:0] data, input bit corrupt);
    logic [7:0] s;
    fb[0] = 8'h5A; fb[1] = cmd;
    fb[2] = addr[31:24]; fb[3] = addr[23:16]; fb[4] = addr[15:8]; fb[5] = addr[7:0];
    fb[6] = data[31:24]; fb[7] = data[23:16]; fb[8] = data[15:8]; fb[9] = data[7:0];
    s = 8'h00;
    for (int i = 0; i < 10; i++) s = s + fb[i];
    fb[10] = 8'h00 - s;
    if (corrupt) fb[10] = fb[10] ^ 8'h01;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_range(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send_byte(fb[i]);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [31:0] addr,
                       input logic [31:0] data, input bit corrupt);
    build(cmd, addr, data, corrupt);
    send_range(0, 10);
    repeat (150) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cpu_hold", 64'(cpu_hold), 64'd1);
    chk("R1 tx_sel", 64'(tx_sel), 64'd0);
    chk("R1 tx_valid", 64'(tx_valid), 64'd0);
    chk("R1 cpu_start", 64'(cpu_start), 64'd0);
    chk("R1 mem strobes", 64'({mem_we, mem_re}), 64'd0);
  endtask

  task automatic t_bad_frames;
    int b0 = nlog;
    send_byte(8'h33);
    send_byte(8'hA5);
    frame(8'h01, 32'h4, 32'hDEAD_BEEF, 1'b1);
    chk("R3 bad checksum no reply", 64'(nlog - b0), 64'd0);
    frame(8'h07, 32'h4, 32'h1111_2222, 1'b0);
    chk("R3 unknown cmd no reply", 64'(nlog - b0), 64'd0);
    chk("R3 no memory write", 64'(nwr), 64'd0);
    chk("R3 tx_sel unchanged", 64'(tx_sel), 64'd0);
  endtask

  task automatic t_write;
    int b0 = nlog;
    send_byte(8'h00);
    send_byte(8'h77);
    frame(8'h01, 32'hFFFF_FF05, 32'h1234_5678, 1'b0);
    chk("R4 ack count", 64'(nlog - b0), 64'd1);
    chk("R4 ack byte", 64'(txlog[b0[7:0]]), 64'hA5);
    chk("R4 tx_sel owned", 64'(tx_sel), 64'd1);
    chk("R5 one write", 64'(nwr), 64'd1);
    chk("R5 write addr", 64'(last_wa), 64'h05);
    chk("R2 R5 write data", 64'(last_wd), 64'h1234_5678);
  endtask

  task automatic t_read;
    int b0;
    frame(8'h01, 32'h0000_0006, 32'hCAFE_0042, 1'b0);
    b0 = nlog;
    frame(8'h02, 32'h0000_0005, 32'h0, 1'b0);
    chk("R6 reply length", 64'(nlog - b0), 64'd5);
    chk("R6 reply bytes", {24'h0, txlog[b0[7:0]], txlog[8'(b0+1)], txlog[8'(b0+2)],
                           txlog[8'(b0+3)], txlog[8'(b0+4)]}, 64'hA5_1234_5678);
    b0 = nlog;
    frame(8'h02, 32'h0000_0006, 32'h0, 1'b0);
    chk("R6 second word", {24'h0, txlog[b0[7:0]], txlog[8'(b0+1)], txlog[8'(b0+2)],
                           txlog[8'(b0+3)], txlog[8'(b0+4)]}, 64'hA5_CAFE_0042);
    chk("R11 handshake held", 64'(hs_err), 64'd0);
  endtask

  task automatic t_timeout;
    int w0 = nwr;
    build(8'h01, 32'h9, 32'h0, 1'b0);
    send_range(0, 3);
    repeat (LIMIT + 5) @(negedge clk);
    frame(8'h01, 32'h0000_0009, 32'h0BAD_F00D, 1'b0);
    chk("R10 partial dropped", 64'(nwr - w0), 64'd1);
    chk("R10 new frame addr", 64'(last_wa), 64'h09);
    build(8'h01, 32'h0A, 32'h5555_AAAA, 1'b0);
    send_range(0, 5);
    repeat (LIMIT - 20) @(negedge clk);
    send_range(6, 10);
    repeat (150) @(negedge clk);
    chk("R10 short gap continues", 64'(nwr - w0), 64'd2);
    chk("R10 continued data", 64'(last_wd), 64'h5555_AAAA);
  endtask

  task automatic t_start;
    frame(8'h03, 32'h0, 32'h8000_0100, 1'b0);
    chk("R7 start address", 64'(cpu_start_addr), 64'h8000_0100);
    chk("R8 no pulse yet", 64'(nstart), 64'd0);
    frame(8'h04, 32'h0, 32'h0, 1'b0);
    chk("R8 one pulse", 64'(nstart), 64'd1);
    chk("R8 single cycle", 64'(wide_err), 64'd0);
    chk("R8 after ack done", 64'(start_cyc > last_acc + BYTE_CYC), 64'd1);
    chk("R8 hold released", 64'(cpu_hold), 64'd0);
    chk("R8 tx back to cpu", 64'(tx_sel), 64'd0);
  endtask

  task automatic t_running;
    int b0 = nlog;
    int w0 = nwr;
    frame(8'h01, 32'h0000_0003, 32'h7777_7777, 1'b0);
    frame(8'h03, 32'h0, 32'h0000_2000, 1'b0);
    frame(8'h04, 32'h0, 32'h0, 1'b0);
    chk("R9 all acked", 64'(nlog - b0), 64'd3);
    chk("R9 no write", 64'(nwr - w0), 64'd0);
    chk("R9 start addr kept", 64'(cpu_start_addr), 64'h8000_0100);
    chk("R9 no second pulse", 64'(nstart), 64'd1);
    chk("R9 still running", 64'(cpu_hold), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bad_frames();
    t_write();
    t_read();
    t_timeout();
    t_start();
    t_running();
    chk("R11 handshake overall", 64'(hs_err), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule